// File: doc/BRIEF.md
# Closed-Loop PWM Voltage Trim Controller

This block holds the output voltages of up to four external converters at programmable targets. For each channel it produces a 10-bit-duty PWM trim signal, which an external RC filter turns into a trim voltage, and a converter enable. A shared stream of 10-bit ADC results, each tagged with a channel index, feeds back the measured voltage. Each channel smooths its own results with a four-sample moving average. It learns whether more duty raises or lowers the output, then moves the duty one step per new filtered value until the filtered value matches the channel's target.

A channel can start in one of two ways. In the normal way the converter is enabled at once, and the channel learns the polarity with a small test step from mid-scale. The test step doubles on each attempt that shows no movement. In precharge mode the trim output is held high for a fixed number of cycles, so that the external filter charges before the converter is enabled. The channel then takes positive polarity and walks the duty down from full scale. Per-channel flags report a learned polarity, a failed learn, a duty stuck at a limit, and a settled regulation.

Top module: `pwm_trim_ctrl`

## Requirements
- R1: A free-running 10-bit counter is shared by all channels. Outside precharge, each channel's trim output is high in exactly `duty` of every 1024 consecutive cycles, so duty 0 keeps it low and larger duties widen the pulse.
- R2: A sample updates only the channel named by `smp_chan` (0 to 3). Samples sent to a channel whose converter enable is low are discarded.
- R3: The filtered value is the sum of a channel's last four accepted samples divided by four, with the remainder dropped. A channel acts only on a sample that leaves its window full, so the first three samples after enabling leave the duty unchanged.
- R4: Without precharge, enabling a channel raises `conv_en` at the next clock edge. The first filtered value is stored as the reference, and the duty goes from 512 to 516. The next filtered value sets `learned`: above the reference means higher duty raises the output, and below it means the opposite.
- R5: When the learn compare shows no change, the duty is raised again by 8, 16 and then 32, and the reference is updated each time. A fourth equal compare sets `learn_fail` and freezes the duty (572 from mid-scale).
- R6: Once learned, each new filtered value moves the duty by exactly one step, in the direction that moves the output toward the target. An equal value leaves the duty unchanged, and no other event changes it.
- R7: The duty never passes 0 or 1023. A step blocked by a limit sets `out_of_range`. A step taken, or a filtered value equal to the target, clears it.
- R8: `in_reg` is high once four consecutive filtered values in regulation lie within one LSB of the target. Any value outside that band clears it.
- R9: In precharge mode, enabling a channel sets the duty to 1023. The trim output is held high, and `conv_en` stays low, for PRE_CYC clock edges. At the next edge `conv_en` rises and the channel starts regulating with positive polarity and `learned` set.
- R10: Dropping `ch_on` clears `conv_en`, every flag and the sample window at the next edge, and returns the duty to 512.
- R11: After reset, every duty is 512 and every output flag and enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | ADC sample strobe |
| smp_chan | input | 2 | Channel index of the sample |
| smp_data | input | 10 | ADC result |
| target_flat | input | 40 | Per-channel target codes, channel n at bits [10n+9:10n] |
| ch_on | input | 4 | Per-channel run request |
| precharge_mode | input | 4 | Per-channel start in precharge mode |
| conv_en | output | 4 | Converter enables |
| trim_pwm | output | 4 | PWM trim outputs |
| duty_flat | output | 40 | Current duties, same packing as targets |
| learned | output | 4 | Polarity known |
| learn_fail | output | 4 | Polarity learn gave up |
| out_of_range | output | 4 | Step blocked at a duty limit |
| in_reg | output | 4 | Settled within one LSB of target |

## Verification
Each channel is driven into a different start path: positive polarity, negative polarity, learn success after one retry, four-attempt learn failure, and a precharge start. Each path is followed by a sweep of sample values that puts the filtered value below, at and above the target. The bench keeps its own model of the four-sample window and of the duty, so any slip in the averaging, the step direction for either polarity, or the single-step rate shows up as a wrong duty. Settling runs of samples at the target test the one-LSB band and the four-value count. Samples sent to disabled channels show whether the channel gating holds. PWM high-time counts over a full period at several duties, and a precharged channel driven against the 1023 limit, cover the output stage and saturation.

// File: rtl/pwm_trim_ctrl.sv
module pwm_trim_ctrl #(
  parameter int NCH     = 4,
  parameter int DW      = 10,
  parameter int PRE_CYC = 16,
  parameter int LSTEP   = 4,
  parameter int LTRIES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [1:0]           smp_chan,
  input  logic [DW-1:0]        smp_data,
  input  logic [NCH*DW-1:0]    target_flat,
  input  logic [NCH-1:0]       ch_on,
  input  logic [NCH-1:0]       precharge_mode,
  output logic [NCH-1:0]       conv_en,
  output logic [NCH-1:0]       trim_pwm,
  output logic [NCH*DW-1:0]    duty_flat,
  output logic [NCH-1:0]       learned,
  output logic [NCH-1:0]       learn_fail,
  output logic [NCH-1:0]       out_of_range,
  output logic [NCH-1:0]       in_reg
);
  localparam logic [DW-1:0] DMAX = '1;
  localparam logic [DW-1:0] DMID = DW'(1) << (DW-1);
  localparam int TW  = (LTRIES > 1) ? $clog2(LTRIES) : 1;
  localparam int PCW = $clog2(PRE_CYC + 1);
  localparam int SW  = DW + 2;

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_LBASE, ST_LWAIT, ST_REG, ST_FAIL} st_t;

  st_t             st      [NCH];
  logic [DW-1:0]   duty    [NCH];
  logic [DW-1:0]   win     [NCH][4];
  logic [2:0]      wcnt    [NCH];
  logic [DW-1:0]   refv    [NCH];
  logic [TW-1:0]   tries   [NCH];
  logic [2:0]      rcnt    [NCH];
  logic [PCW-1:0]  pre_cnt [NCH];
  logic [NCH-1:0]  fnew, pol;
  logic [DW-1:0]   pcnt;

  logic [DW-1:0]   avg     [NCH];
  logic [DW-1:0]   tgt     [NCH];
  logic [DW-1:0]   lnext   [NCH];
  logic [NCH-1:0]  raise, lower, near, hit, active;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      logic [SW-1:0] sum;
      logic [TW:0]   sh;
      logic [DW:0]   step, sumd;
      sum = {2'b0, win[c][0]} + {2'b0, win[c][1]} + {2'b0, win[c][2]} + {2'b0, win[c][3]};
      avg[c] = sum[SW-1:2];
      tgt[c] = target_flat[c*DW +: DW];
      raise[c] = pol[c] ? (avg[c] < tgt[c]) : (avg[c] > tgt[c]);
      lower[c] = pol[c] ? (avg[c] > tgt[c]) : (avg[c] < tgt[c]);
      near[c]  = ({1'b0, avg[c]} + 1'b1 >= {1'b0, tgt[c]}) && ({1'b0, avg[c]} <= {1'b0, tgt[c]} + 1'b1);
      sh   = (st[c] == ST_LWAIT) ? ({1'b0, tries[c]} + 1'b1) : '0;
      step = (DW+1)'(LSTEP) << sh;
      sumd = {1'b0, duty[c]} + step;
      lnext[c] = (sumd > {1'b0, DMAX}) ? DMAX : sumd[DW-1:0];
      active[c] = (st[c] != ST_IDLE) && (st[c] != ST_PRE);
      hit[c] = smp_valid && (32'(smp_chan) == c) && active[c];
      conv_en[c]      = active[c];
      trim_pwm[c]     = (st[c] == ST_PRE) || (pcnt < duty[c]);
      duty_flat[c*DW +: DW] = duty[c];
      in_reg[c]       = (rcnt[c] == 3'd4);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      fnew <= '0; pol <= '0; learned <= '0; learn_fail <= '0; out_of_range <= '0;
      for (int c = 0; c < NCH; c++) begin
        st[c] <= ST_IDLE; duty[c] <= DMID; wcnt[c] <= '0; refv[c] <= '0;
        tries[c] <= '0; rcnt[c] <= '0; pre_cnt[c] <= '0;
        for (int k = 0; k < 4; k++) win[c][k] <= '0;
      end
    end else begin
      pcnt <= pcnt + 1'b1;
      for (int c = 0; c < NCH; c++) begin
        fnew[c] <= 1'b0;
        if (!ch_on[c]) begin
          st[c] <= ST_IDLE; duty[c] <= DMID; wcnt[c] <= '0; tries[c] <= '0;
          rcnt[c] <= '0; pre_cnt[c] <= '0; pol[c] <= 1'b0;
          learned[c] <= 1'b0; learn_fail[c] <= 1'b0; out_of_range[c] <= 1'b0;
          for (int k = 0; k < 4; k++) win[c][k] <= '0;
        end else begin
          if (hit[c]) begin
            win[c][0] <= smp_data;
            for (int k = 1; k < 4; k++) win[c][k] <= win[c][k-1];
            if (wcnt[c] < 3'd4) wcnt[c] <= wcnt[c] + 1'b1;
            fnew[c] <= (wcnt[c] >= 3'd3);
          end
          case (st[c])
            ST_IDLE:
              if (precharge_mode[c]) begin
                st[c] <= ST_PRE; duty[c] <= DMAX; pre_cnt[c] <= '0;
              end else st[c] <= ST_LBASE;
            ST_PRE:
              if (pre_cnt[c] == PCW'(PRE_CYC - 1)) begin
                st[c] <= ST_REG; pol[c] <= 1'b1; learned[c] <= 1'b1;
              end else pre_cnt[c] <= pre_cnt[c] + 1'b1;
            ST_LBASE:
              if (fnew[c]) begin
                refv[c] <= avg[c]; duty[c] <= lnext[c]; st[c] <= ST_LWAIT;
              end
            ST_LWAIT:
              if (fnew[c]) begin
                if (avg[c] != refv[c]) begin
                  pol[c] <= (avg[c] > refv[c]); learned[c] <= 1'b1; st[c] <= ST_REG;
                end else if (tries[c] == TW'(LTRIES - 1)) begin
                  learn_fail[c] <= 1'b1; st[c] <= ST_FAIL;
                end else begin
                  tries[c] <= tries[c] + 1'b1; refv[c] <= avg[c]; duty[c] <= lnext[c];
                end
              end
            ST_REG:
              if (fnew[c]) begin
                if (raise[c]) begin
                  if (duty[c] == DMAX) out_of_range[c] <= 1'b1;
                  else begin duty[c] <= duty[c] + 1'b1; out_of_range[c] <= 1'b0; end
                end else if (lower[c]) begin
                  if (duty[c] == '0) out_of_range[c] <= 1'b1;
                  else begin duty[c] <= duty[c] - 1'b1; out_of_range[c] <= 1'b0; end
                end else out_of_range[c] <= 1'b0;
                if (near[c]) begin
                  if (rcnt[c] != 3'd4) rcnt[c] <= rcnt[c] + 1'b1;
                end else rcnt[c] <= '0;
              end
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_off_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_on[g] |=> (!conv_en[g] && duty[g] == DMID && !learned[g] && !in_reg[g]));
    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == ST_REG && ch_on[g]) |=> (duty[g] == $past(duty[g]) ||
        duty[g] == $past(duty[g]) + 1'b1 || duty[g] == $past(duty[g]) - 1'b1));
    assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == ST_REG && ch_on[g] && !fnew[g]) |=> $stable(duty[g]));
    assert_precharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_en[g]) && learned[g] |-> duty[g] == DMAX);
    assert_settled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_reg[g] |-> (learned[g] && conv_en[g]));
    assert_fail_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (learn_fail[g] && ch_on[g]) |=> (!learned[g] && $stable(duty[g])));
  end
endmodule

// File: tb/pwm_trim_ctrl_tb.sv
module pwm_trim_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0;
  logic [1:0] smp_chan = 0;
  logic [9:0] smp_data = 0;
  logic [39:0] target_flat;
  logic [3:0] ch_on = 0, precharge_mode = 0;
  logic [3:0] conv_en, trim_pwm, learned, learn_fail, out_of_range, in_reg;
  logic [39:0] duty_flat;
  int tg [4];
  int total = 0, bad = 0;

  always #5 clk = ~clk;
  always_comb for (int c = 0; c < 4; c++) target_flat[c*10 +: 10] = 10'(tg[c]);

  pwm_trim_ctrl u_dut (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .target_flat(target_flat), .ch_on(ch_on), .precharge_mode(precharge_mode),
    .conv_en(conv_en), .trim_pwm(trim_pwm), .duty_flat(duty_flat), .learned(learned),
    .learn_fail(learn_fail), .out_of_range(out_of_range), .in_reg(in_reg));

  // model: 0 idle 1 pre 2 base 3 wait 4 reg 5 fail
  int m_w [4][4];
  int m_n [4], m_st [4], m_duty [4], m_pol [4], m_tries [4], m_ref [4], m_rc [4], m_oor [4], m_fail [4], m_lrn [4];

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_clear(int c);
    for (int k = 0; k < 4; k++) m_w[c][k] = 0;
    m_n[c] = 0; m_st[c] = 0; m_duty[c] = 512; m_pol[c] = 0; m_tries[c] = 0;
    m_ref[c] = 0; m_rc[c] = 0; m_oor[c] = 0; m_fail[c] = 0; m_lrn[c] = 0;
  endtask

  task automatic m_sample(int c, int v);
    int avg;
    if (m_st[c] < 2) return;
    for (int k = 3; k > 0; k--) m_w[c][k] = m_w[c][k-1];
    m_w[c][0] = v;
    if (m_n[c] < 4) m_n[c]++;
    if (m_n[c] < 4) return;
    avg = (m_w[c][0] + m_w[c][1] + m_w[c][2] + m_w[c][3]) / 4;
    case (m_st[c])
      2: begin m_ref[c] = avg; m_duty[c] = m_duty[c] + 4; m_st[c] = 3; end
      3: if (avg != m_ref[c]) begin
           m_pol[c] = (avg > m_ref[c]); m_lrn[c] = 1; m_st[c] = 4;
         end else if (m_tries[c] == 3) begin
           m_fail[c] = 1; m_st[c] = 5;
         end else begin
           m_tries[c]++; m_ref[c] = avg;
           m_duty[c] = m_duty[c] + (4 << m_tries[c]);
           if (m_duty[c] > 1023) m_duty[c] = 1023;
         end
      4: begin
           bit up, dn;
           up = m_pol[c] ? (avg < tg[c]) : (avg > tg[c]);
           dn = m_pol[c] ? (avg > tg[c]) : (avg < tg[c]);
           if (up) begin
             if (m_duty[c] == 1023) m_oor[c] = 1; else begin m_duty[c]++; m_oor[c] = 0; end
           end else if (dn) begin
             if (m_duty[c] == 0) m_oor[c] = 1; else begin m_duty[c]--; m_oor[c] = 0; end
           end else m_oor[c] = 0;
           if (avg - tg[c] <= 1 && tg[c] - avg <= 1) begin
             if (m_rc[c] < 4) m_rc[c]++;
           end else m_rc[c] = 0;
         end
      default: ;
    endcase
  endtask

  task automatic check_ch(int c, string req);
    chk({req, " duty"}, int'(duty_flat[c*10 +: 10]), m_duty[c]);
    chk({req, " conv_en"}, int'(conv_en[c]), int'(m_st[c] >= 2));
    chk({req, " learned"}, int'(learned[c]), m_lrn[c]);
    chk({req, " learn_fail"}, int'(learn_fail[c]), m_fail[c]);
    chk({req, " out_of_range"}, int'(out_of_range[c]), m_oor[c]);
    chk({req, " in_reg"}, int'(in_reg[c]), int'(m_rc[c] == 4));
  endtask

  task automatic send(int c, int v, string req);
    @(negedge clk);
    smp_valid = 1; smp_chan = 2'(c); smp_data = 10'(v);
    @(negedge clk);
    smp_valid = 0;
    repeat (2) @(negedge clk);
    m_sample(c, v);
    check_ch(c, req);
  endtask

  task automatic enable(int c);
    @(negedge clk);
    ch_on[c] = 1;
    @(negedge clk);
    m_st[c] = 2;
    check_ch(c, "R4 enable");
  endtask

  task automatic pwm_count(int c, string req);
    int n = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (trim_pwm[c]) n++;
    end
    chk(req, n, m_duty[c]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin m_clear(c); tg[c] = 0; end
    tg[0] = 130; tg[1] = 280; tg[2] = 400; tg[3] = 300;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) check_ch(c, "R11 reset");

    // R2: samples to a disabled channel are dropped
    for (int i = 0; i < 4; i++) send(0, 50, "R2 off");
    enable(0);
    // R3: three samples fill the window without any action
    for (int i = 0; i < 3; i++) send(0, 100, "R3 partial");
    send(0, 100, "R4 base step");
    send(0, 200, "R4 positive");
    // R2: ch1 samples (disabled) leave ch0 alone
    send(1, 900, "R2 other channel");
    check_ch(0, "R2 ch0 untouched");
    for (int i = 0; i < 14; i++) send(0, 40 + 20 * i, "R6 sweep pos");
    for (int i = 0; i < 6; i++) send(0, 130, "R8 settle");
    send(0, 131, "R8 one lsb");
    send(0, 900, "R8 leave band");

    // negative polarity
    enable(1);
    for (int i = 0; i < 4; i++) send(1, 300, "R4 base");
    send(1, 100, "R4 negative");
    for (int i = 0; i < 12; i++) send(1, 200 + 15 * i, "R6 sweep neg");
    for (int i = 0; i < 6; i++) send(1, 280, "R8 settle neg");

    // learn failure
    enable(2);
    for (int i = 0; i < 8; i++) send(2, 400, "R5 retry/fail");
    for (int i = 0; i < 3; i++) send(2, 700, "R5 frozen");

    // retry then success
    enable(3);
    for (int i = 0; i < 4; i++) send(3, 500, "R5 base");
    send(3, 500, "R5 retry");
    send(3, 600, "R5 late learn");
    for (int i = 0; i < 4; i++) send(3, 200, "R6 ch3");

    // R1 PWM high-time
    for (int c = 0; c < 4; c++) pwm_count(c, "R1 pwm count");

    // R10 disable
    @(negedge clk);
    ch_on[3] = 0;
    @(negedge clk);
    m_clear(3);
    check_ch(3, "R10 disable");
    send(3, 700, "R10 off sample");

    // R9 precharge start
    precharge_mode[3] = 1;
    tg[3] = 600;
    @(negedge clk);
    ch_on[3] = 1;
    repeat (16) @(negedge clk);
    chk("R9 conv_en low", int'(conv_en[3]), 0);
    chk("R9 trim high", int'(trim_pwm[3]), 1);
    chk("R9 duty max", int'(duty_flat[39:30]), 1023);
    @(negedge clk);
    m_st[3] = 4; m_duty[3] = 1023; m_pol[3] = 1; m_lrn[3] = 1;
    check_ch(3, "R9 enabled");
    // R7: below target with duty at 1023 is blocked
    for (int i = 0; i < 5; i++) send(3, 100, "R7 limit");
    for (int i = 0; i < 6; i++) send(3, 900, "R7 release");
    pwm_count(3, "R1 pwm after walk");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule